// File: doc/BRIEF.md
# Power-Fail Cache Backup Sequencer

This block guards the contents of a volatile DRAM cache when the main supply drops. While power is good it sits idle and keeps every memory-bus driver disabled, so the host memory controller can use the bus. It only watches the power-status input, the register reset and the cache-dirty sideband. When power fails and the cache holds written-over data, the block takes the bus. It reads every cache word in ascending address order and streams each 72-bit word, check bits included, unchanged into a set of narrow flash channels. If the cache is clean when power fails, the copy is skipped and the block reports that at once.

Once power is back, a restore request reads each word out of flash again, rebuilds it and writes it into DRAM. In this mode the block drives the bus itself, and each DRAM write strobe is held for several clock cycles, which gives a lower data rate than the host uses. A flash write failure stops a backup and leaves a sticky fault indication. An active-low register reset clears the status and aborts a restore, but it cannot stop a backup that is running.

Top module: `cache_backup_ctrl`

## Requirements
- R1: After the asynchronous reset `rstN`, the block is idle: `busOwn`, `memOe`, `done` and `errSticky` are 0 and `statusCode` is 0 (none).
- R2: Whenever `busOwn` is 0, `memOe`, `memRdReq` and `memWrEn` are 0 and `memAddr` and `memWrData` read as zero (drivers released).
- R3: Bus takeover has a one-cycle turnaround. `busOwn` rises one cycle before `memOe`, and `memOe` is never 1 unless `busOwn` was already 1 in the previous cycle.
- R4: When `powerGood` is low in idle with `cacheDirtyN` low, the block takes the bus and issues exactly one DRAM read (`memRdReq` with `memAddr`) per word, for addresses 0 to DEPTH-1 in ascending order. The next read waits until the current word has been acknowledged by flash.
- R5: Each word is sent as BEATS consecutive `flashWrValid` beats, with `flashAddr` equal to the word address. Nibble k (word bits 4k+3:4k) goes out in beat k/4 on channel k%4, and channel c occupies `flashWrData[4c+3:4c]`. Channel slots beyond nibble 17 carry zero.
- R6: When `powerGood` is low in idle with `cacheDirtyN` high, `busOwn` stays 0. In the next cycle `done` is 1 and `statusCode` is 2 (skipped).
- R7: When flash acknowledges the last word (`flashAck` with `flashFail` low), the bus is released in the next cycle, with `done` = 1 and `statusCode` = 1 (saved).
- R8: A `flashAck` with `flashFail` high during a backup stops the sequence. In the next cycle `busOwn` = 0, `errSticky` = 1 and `statusCode` = 4 (fault). These hold until `regRstN` is low.
- R9: While a backup is running, `regRstN` low has no effect: the backup continues to completion.
- R10: A `restoreReq` in idle or after a finished backup, with `powerGood` high and `cacheDirtyN` low, takes the bus. For each address 0 to DEPTH-1 the block issues `flashRdReq` and collects BEATS `flashRdValid` beats using the R5 mapping. It then writes the rebuilt word to that DRAM address. At the end `done` = 1, `statusCode` = 3 (restored) and the bus is released.
- R11: A `restoreReq` while `cacheDirtyN` is high or `powerGood` is low is ignored: `busOwn` stays 0 and `statusCode` keeps its value.
- R12: `regRstN` low outside a backup returns the block to idle within one cycle. It clears `done`, `statusCode` and `errSticky` and aborts a restore in progress.
- R13: During a restore each DRAM write holds `memWrEn`, `memAddr` and `memWrData` for exactly SLOW_DIV consecutive cycles (SLOW_DIV at least 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regRstN | input | 1 | Active-low register reset (status clear, idle return) |
| powerGood | input | 1 | System power status, 1 = good |
| cacheDirtyN | input | 1 | Active-low cache-dirty sideband |
| restoreReq | input | 1 | Request to restore DRAM from flash |
| busOwn | output | 1 | Block owns the memory bus |
| memOe | output | 1 | Memory-bus driver enable |
| memAddr | output | AW | DRAM word address |
| memRdReq | output | 1 | DRAM read command strobe |
| memRdValid | input | 1 | DRAM read data valid |
| memRdData | input | 72 | DRAM read word (64 data + 8 check) |
| memWrEn | output | 1 | DRAM write strobe (stretched) |
| memWrData | output | 72 | DRAM write word |
| flashAddr | output | AW | Flash word address |
| flashWrValid | output | 1 | Flash write beat valid |
| flashWrData | output | 16 | Four 4-bit flash channels |
| flashAck | input | 1 | Flash word commit response |
| flashFail | input | 1 | Commit failed, qualified by flashAck |
| flashRdReq | output | 1 | Flash word read request |
| flashRdValid | input | 1 | Flash read beat valid |
| flashRdData | input | 16 | Flash read beat, four channels |
| done | output | 1 | Sequence finished |
| statusCode | output | 3 | 0 none, 1 saved, 2 skipped, 3 restored, 4 fault |
| errSticky | output | 1 | Sticky flash-failure flag |

## Verification
The properties assume that `flashAck` and `flashFail` only count while the block waits for a word commit. They also assume that `regRstN` can arrive at any time, so the hold-time property on DRAM writes is qualified by `regRstN` being high. The stimulus drives every response only after the matching request has been seen: a DRAM read return, a flash acknowledge after the last beat, and flash read beats after a read request. Register reset is pulsed during a restore only between write strobes, so a stretched write is never cut short while its length is being measured.

// File: rtl/cbk_pkg.sv
package cbk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARBITRATE,
    ST_BACKUP,
    ST_BACKUP_DONE,
    ST_RESTORE,
    ST_ERROR
  } cbkState_e;

  // sub-steps of the two copy directions
  typedef enum logic [2:0] {
    PH_RDREQ,
    PH_RDWAIT,
    PH_WBEAT,
    PH_ACK,
    PH_FRREQ,
    PH_FRBEAT,
    PH_DWR
  } cbkPhase_e;

  localparam logic [2:0] STAT_NONE     = 3'd0;
  localparam logic [2:0] STAT_SAVED    = 3'd1;
  localparam logic [2:0] STAT_SKIPPED  = 3'd2;
  localparam logic [2:0] STAT_RESTORED = 3'd3;
  localparam logic [2:0] STAT_FAULT    = 3'd4;

  typedef struct packed {
    logic clrAddr;
    logic incAddr;
    logic capWord;
    logic loadBeat;
    logic oe;
    logic driveRd;
    logic driveWr;
    logic driveFlashWr;
    logic driveFlashRd;
  } cbkStrobe_t;

endpackage

// File: rtl/cbk_datapath.sv
module cbk_datapath
  import cbk_pkg::*;
#(
  parameter int WORD_W = 72,
  parameter int CH     = 4,
  parameter int NIB_W  = 4,
  parameter int DEPTH  = 16,
  parameter int BEATS  = 5,
  parameter int BW     = 3,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  cbkStrobe_t        strobe,
  input  logic [BW-1:0]     beatIdx,
  input  logic [WORD_W-1:0] memRdData,
  input  logic [CH*NIB_W-1:0] flashRdData,
  output logic [AW-1:0]     memAddr,
  output logic              memRdReq,
  output logic              memWrEn,
  output logic [WORD_W-1:0] memWrData,
  output logic [AW-1:0]     flashAddr,
  output logic              flashWrValid,
  output logic [CH*NIB_W-1:0] flashWrData,
  output logic              flashRdReq,
  output logic              lastWord
);

  localparam int NIBS = WORD_W / NIB_W;

  logic [AW-1:0]     wordAddr;
  logic [WORD_W-1:0] wordReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordAddr <= '0;
    end else if (strobe.clrAddr) begin
      wordAddr <= '0;
    end else if (strobe.incAddr) begin
      wordAddr <= wordAddr + 1'b1;
    end
  end

  assign lastWord = (wordAddr == AW'(DEPTH - 1));

  // word holding register: whole word from DRAM, or one beat at a time from flash
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordReg <= '0;
    end else if (strobe.capWord) begin
      wordReg <= memRdData;
    end else if (strobe.loadBeat) begin
      for (int c = 0; c < CH; c++) begin
        if (int'(beatIdx) * CH + c < NIBS)
          wordReg[(int'(beatIdx) * CH + c) * NIB_W +: NIB_W] <= flashRdData[c * NIB_W +: NIB_W];
      end
    end
  end

  // per-channel beat slicing
  for (genvar c = 0; c < CH; c++) begin : g_chan
    always_comb begin
      flashWrData[c * NIB_W +: NIB_W] = '0;
      if (strobe.driveFlashWr && (int'(beatIdx) * CH + c < NIBS))
        flashWrData[c * NIB_W +: NIB_W] = wordReg[(int'(beatIdx) * CH + c) * NIB_W +: NIB_W];
    end
  end

  assign memAddr      = strobe.oe ? wordAddr : '0;
  assign memRdReq     = strobe.oe & strobe.driveRd;
  assign memWrEn      = strobe.oe & strobe.driveWr;
  assign memWrData    = (strobe.oe & strobe.driveWr) ? wordReg : '0;
  assign flashWrValid = strobe.driveFlashWr;
  assign flashRdReq   = strobe.driveFlashRd;
  assign flashAddr    = (strobe.driveFlashWr | strobe.driveFlashRd) ? wordAddr : '0;

endmodule

// File: rtl/cbk_ctrl.sv
module cbk_ctrl
  import cbk_pkg::*;
#(
  parameter int BEATS    = 5,
  parameter int BW       = 3,
  parameter int SLOW_DIV = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regRstN,
  input  logic          powerGood,
  input  logic          cacheDirtyN,
  input  logic          restoreReq,
  input  logic          memRdValid,
  input  logic          flashAck,
  input  logic          flashFail,
  input  logic          flashRdValid,
  input  logic          lastWord,
  output cbkStrobe_t    strobe,
  output logic [BW-1:0] beatIdx,
  output logic          busOwn,
  output logic          doneFlag,
  output logic [2:0]    statusCode,
  output logic          errSticky,
  output cbkState_e     curState,
  output cbkPhase_e     curPhase
);

  localparam int SW = $clog2(SLOW_DIV + 1);

  cbkState_e     state;
  cbkPhase_e     phase;
  logic          toRestore;
  logic [BW-1:0] beatCnt;
  logic [SW-1:0] slowCnt;
  logic          lastBeat;
  logic          slowDone;
  logic          restoreOk;

  assign lastBeat  = (beatCnt == BW'(BEATS - 1));
  assign slowDone  = (slowCnt == SW'(SLOW_DIV - 1));
  assign restoreOk = restoreReq & powerGood & ~cacheDirtyN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      phase      <= PH_RDREQ;
      toRestore  <= 1'b0;
      beatCnt    <= '0;
      slowCnt    <= '0;
      doneFlag   <= 1'b0;
      statusCode <= STAT_NONE;
      errSticky  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!powerGood) begin
            if (!cacheDirtyN) begin
              state      <= ST_ARBITRATE;
              toRestore  <= 1'b0;
              doneFlag   <= 1'b0;
              statusCode <= STAT_NONE;
            end else begin
              state      <= ST_BACKUP_DONE;
              doneFlag   <= 1'b1;
              statusCode <= STAT_SKIPPED;
            end
          end else if (!regRstN) begin
            doneFlag   <= 1'b0;
            statusCode <= STAT_NONE;
            errSticky  <= 1'b0;
          end else if (restoreOk) begin
            state      <= ST_ARBITRATE;
            toRestore  <= 1'b1;
            doneFlag   <= 1'b0;
            statusCode <= STAT_NONE;
          end
        end

        ST_ARBITRATE: begin
          beatCnt <= '0;
          slowCnt <= '0;
          if (toRestore && !regRstN) begin
            state <= ST_IDLE;
          end else if (toRestore) begin
            state <= ST_RESTORE;
            phase <= PH_FRREQ;
          end else begin
            state <= ST_BACKUP;
            phase <= PH_RDREQ;
          end
        end

        ST_BACKUP: begin
          case (phase)
            PH_RDREQ:  phase <= PH_RDWAIT;
            PH_RDWAIT: begin
              if (memRdValid) begin
                phase   <= PH_WBEAT;
                beatCnt <= '0;
              end
            end
            PH_WBEAT: begin
              if (lastBeat) begin
                phase   <= PH_ACK;
                beatCnt <= '0;
              end else begin
                beatCnt <= beatCnt + 1'b1;
              end
            end
            PH_ACK: begin
              if (flashAck) begin
                if (flashFail) begin
                  state      <= ST_ERROR;
                  errSticky  <= 1'b1;
                  statusCode <= STAT_FAULT;
                end else if (lastWord) begin
                  state      <= ST_BACKUP_DONE;
                  doneFlag   <= 1'b1;
                  statusCode <= STAT_SAVED;
                end else begin
                  phase <= PH_RDREQ;
                end
              end
            end
            default: phase <= PH_RDREQ;
          endcase
        end

        ST_BACKUP_DONE: begin
          if (!regRstN) begin
            state      <= ST_IDLE;
            doneFlag   <= 1'b0;
            statusCode <= STAT_NONE;
            errSticky  <= 1'b0;
          end else if (restoreOk) begin
            state      <= ST_ARBITRATE;
            toRestore  <= 1'b1;
            doneFlag   <= 1'b0;
            statusCode <= STAT_NONE;
          end
        end

        ST_RESTORE: begin
          if (!regRstN) begin
            state      <= ST_IDLE;
            doneFlag   <= 1'b0;
            statusCode <= STAT_NONE;
            errSticky  <= 1'b0;
          end else begin
            case (phase)
              PH_FRREQ: begin
                phase   <= PH_FRBEAT;
                beatCnt <= '0;
              end
              PH_FRBEAT: begin
                if (flashRdValid) begin
                  if (lastBeat) begin
                    phase   <= PH_DWR;
                    beatCnt <= '0;
                    slowCnt <= '0;
                  end else begin
                    beatCnt <= beatCnt + 1'b1;
                  end
                end
              end
              PH_DWR: begin
                if (slowDone) begin
                  slowCnt <= '0;
                  if (lastWord) begin
                    state      <= ST_IDLE;
                    doneFlag   <= 1'b1;
                    statusCode <= STAT_RESTORED;
                  end else begin
                    phase <= PH_FRREQ;
                  end
                end else begin
                  slowCnt <= slowCnt + 1'b1;
                end
              end
              default: phase <= PH_FRREQ;
            endcase
          end
        end

        ST_ERROR: begin
          if (!regRstN) begin
            state      <= ST_IDLE;
            doneFlag   <= 1'b0;
            statusCode <= STAT_NONE;
            errSticky  <= 1'b0;
          end
        end

        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe              = '0;
    strobe.clrAddr      = (state == ST_ARBITRATE);
    strobe.oe           = (state == ST_BACKUP) || (state == ST_RESTORE);
    strobe.driveRd      = (state == ST_BACKUP) && (phase == PH_RDREQ);
    strobe.capWord      = (state == ST_BACKUP) && (phase == PH_RDWAIT) && memRdValid;
    strobe.driveFlashWr = (state == ST_BACKUP) && (phase == PH_WBEAT);
    strobe.driveFlashRd = (state == ST_RESTORE) && (phase == PH_FRREQ);
    strobe.loadBeat     = (state == ST_RESTORE) && (phase == PH_FRBEAT) && flashRdValid;
    strobe.driveWr      = (state == ST_RESTORE) && (phase == PH_DWR);
    strobe.incAddr      = ((state == ST_BACKUP) && (phase == PH_ACK) && flashAck && !flashFail && !lastWord)
                       || ((state == ST_RESTORE) && (phase == PH_DWR) && regRstN && slowDone && !lastWord);
  end

  assign busOwn   = (state == ST_ARBITRATE) || (state == ST_BACKUP) || (state == ST_RESTORE);
  assign beatIdx  = beatCnt;
  assign curState = state;
  assign curPhase = phase;

endmodule

// File: rtl/cache_backup_ctrl.sv
module cache_backup_ctrl
  import cbk_pkg::*;
#(
  parameter int WORD_W   = 72,
  parameter int CH       = 4,
  parameter int NIB_W    = 4,
  parameter int DEPTH    = 16,
  parameter int SLOW_DIV = 3,
  localparam int AW      = $clog2(DEPTH),
  localparam int FW      = CH * NIB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regRstN,
  input  logic              powerGood,
  input  logic              cacheDirtyN,
  input  logic              restoreReq,
  output logic              busOwn,
  output logic              memOe,
  output logic [AW-1:0]     memAddr,
  output logic              memRdReq,
  input  logic              memRdValid,
  input  logic [WORD_W-1:0] memRdData,
  output logic              memWrEn,
  output logic [WORD_W-1:0] memWrData,
  output logic [AW-1:0]     flashAddr,
  output logic              flashWrValid,
  output logic [FW-1:0]     flashWrData,
  input  logic              flashAck,
  input  logic              flashFail,
  output logic              flashRdReq,
  input  logic              flashRdValid,
  input  logic [FW-1:0]     flashRdData,
  output logic              done,
  output logic [2:0]        statusCode,
  output logic              errSticky
);

  localparam int NIBS  = WORD_W / NIB_W;
  localparam int BEATS = (NIBS + CH - 1) / CH;
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;

  cbkStrobe_t    strobe;
  logic [BW-1:0] beatIdx;
  logic          lastWord;
  cbkState_e     curState;
  cbkPhase_e     curPhase;

  cbk_ctrl #(
    .BEATS   (BEATS),
    .BW      (BW),
    .SLOW_DIV(SLOW_DIV)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .regRstN     (regRstN),
    .powerGood   (powerGood),
    .cacheDirtyN (cacheDirtyN),
    .restoreReq  (restoreReq),
    .memRdValid  (memRdValid),
    .flashAck    (flashAck),
    .flashFail   (flashFail),
    .flashRdValid(flashRdValid),
    .lastWord    (lastWord),
    .strobe      (strobe),
    .beatIdx     (beatIdx),
    .busOwn      (busOwn),
    .doneFlag    (done),
    .statusCode  (statusCode),
    .errSticky   (errSticky),
    .curState    (curState),
    .curPhase    (curPhase)
  );

  cbk_datapath #(
    .WORD_W(WORD_W),
    .CH    (CH),
    .NIB_W (NIB_W),
    .DEPTH (DEPTH),
    .BEATS (BEATS),
    .BW    (BW),
    .AW    (AW)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .beatIdx     (beatIdx),
    .memRdData   (memRdData),
    .flashRdData (flashRdData),
    .memAddr     (memAddr),
    .memRdReq    (memRdReq),
    .memWrEn     (memWrEn),
    .memWrData   (memWrData),
    .flashAddr   (flashAddr),
    .flashWrValid(flashWrValid),
    .flashWrData (flashWrData),
    .flashRdReq  (flashRdReq),
    .lastWord    (lastWord)
  );

  assign memOe = strobe.oe;

endmodule

// File: rtl/cbk_checker.sv
module cbk_checker
  import cbk_pkg::*;
#(
  parameter int AW     = 4,
  parameter int WORD_W = 72
) (
  input logic              clk,
  input logic              rstN,
  input logic              regRstN,
  input logic              powerGood,
  input logic              cacheDirtyN,
  input logic              busOwn,
  input logic              memOe,
  input logic              memRdReq,
  input logic              memWrEn,
  input logic [AW-1:0]     memAddr,
  input logic [WORD_W-1:0] memWrData,
  input logic              flashAck,
  input logic              flashFail,
  input logic              done,
  input logic [2:0]        statusCode,
  input logic              errSticky,
  input cbkState_e         curState,
  input cbkPhase_e         curPhase
);

  p_released_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busOwn |-> (!memOe && !memRdReq && !memWrEn && memAddr == '0 && memWrData == '0));

  p_takeover_turn_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOwn) |-> !memOe);

  p_oe_after_own_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memOe) |-> $past(busOwn));

  p_read_in_backup_r4: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |-> (memOe && curState == ST_BACKUP));

  p_clean_skip_r6: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_IDLE && !powerGood && cacheDirtyN) |=> (!busOwn && done && statusCode == STAT_SKIPPED));

  p_done_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> !busOwn);

  p_fail_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_BACKUP && curPhase == PH_ACK && flashAck && flashFail)
      |=> (errSticky && !busOwn && statusCode == STAT_FAULT));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (errSticky && regRstN) |=> errSticky);

  p_backup_guard_r9: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_BACKUP && !regRstN)
      |=> (curState == ST_BACKUP || curState == ST_BACKUP_DONE || curState == ST_ERROR));

  p_clean_restore_r11: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_IDLE && powerGood && cacheDirtyN) |=> !busOwn);

  p_wr_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(memWrEn) && regRstN) |=> memWrEn);

  p_wr_addr_stable_r13: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && $past(memWrEn)) |-> ($stable(memAddr) && $stable(memWrData)));

endmodule

bind cache_backup_ctrl cbk_checker #(
  .AW    (AW),
  .WORD_W(WORD_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regRstN    (regRstN),
  .powerGood  (powerGood),
  .cacheDirtyN(cacheDirtyN),
  .busOwn     (busOwn),
  .memOe      (memOe),
  .memRdReq   (memRdReq),
  .memWrEn    (memWrEn),
  .memAddr    (memAddr),
  .memWrData  (memWrData),
  .flashAck   (flashAck),
  .flashFail  (flashFail),
  .done       (done),
  .statusCode (statusCode),
  .errSticky  (errSticky),
  .curState   (curState),
  .curPhase   (curPhase)
);

// File: tb/cache_backup_ctrl_tb.sv
module cache_backup_ctrl_tb;

  localparam int WORD_W   = 72;
  localparam int CH       = 4;
  localparam int NIB_W    = 4;
  localparam int DEPTH    = 16;
  localparam int SLOW_DIV = 3;
  localparam int AW       = $clog2(DEPTH);
  localparam int FW       = CH * NIB_W;
  localparam int NIBS     = WORD_W / NIB_W;
  localparam int BEATS    = (NIBS + CH - 1) / CH;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regRstN = 1'b1;
  logic powerGood = 1'b1;
  logic cacheDirtyN = 1'b1;
  logic restoreReq = 1'b0;
  logic busOwn, memOe, memRdReq, memWrEn, flashWrValid, flashRdReq, done, errSticky;
  logic [AW-1:0] memAddr, flashAddr;
  logic memRdValid = 1'b0;
  logic [WORD_W-1:0] memRdData = '0;
  logic [WORD_W-1:0] memWrData;
  logic [FW-1:0] flashWrData;
  logic flashAck = 1'b0;
  logic flashFail = 1'b0;
  logic flashRdValid = 1'b0;
  logic [FW-1:0] flashRdData = '0;
  logic [2:0] statusCode;

  always #5 clk = ~clk;

  cache_backup_ctrl #(
    .WORD_W(WORD_W), .CH(CH), .NIB_W(NIB_W), .DEPTH(DEPTH), .SLOW_DIV(SLOW_DIV)
  ) u_dut (
    .clk(clk), .rstN(rstN), .regRstN(regRstN), .powerGood(powerGood),
    .cacheDirtyN(cacheDirtyN), .restoreReq(restoreReq), .busOwn(busOwn),
    .memOe(memOe), .memAddr(memAddr), .memRdReq(memRdReq), .memRdValid(memRdValid),
    .memRdData(memRdData), .memWrEn(memWrEn), .memWrData(memWrData),
    .flashAddr(flashAddr), .flashWrValid(flashWrValid), .flashWrData(flashWrData),
    .flashAck(flashAck), .flashFail(flashFail), .flashRdReq(flashRdReq),
    .flashRdValid(flashRdValid), .flashRdData(flashRdData), .done(done),
    .statusCode(statusCode), .errSticky(errSticky)
  );

  int unsigned checks = 0;
  int unsigned errors = 0;

  task automatic chk(input bit ok, input string req, input logic [WORD_W-1:0] act,
                     input logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural memories
  logic [WORD_W-1:0] dram [DEPTH];
  logic [WORD_W-1:0] saved [DEPTH];
  logic [FW-1:0]     flashMem [DEPTH][BEATS];

  function automatic logic [FW-1:0] expBeat(logic [WORD_W-1:0] w, int b);
    logic [FW-1:0] r;
    r = '0;
    for (int c = 0; c < CH; c++) begin
      int k;
      k = b * CH + c;
      if (k < NIBS) r[c * NIB_W +: NIB_W] = w[k * NIB_W +: NIB_W];
    end
    return r;
  endfunction

  // responder and per-clock reference state
  int  expRdAddr = 0;
  int  expWrAddr = 0;
  int  rdDelay = 0;
  int  rdAddrD = 0;
  int  wBeat = 0;
  int  ackCnt = 0;
  int  ackAddr = 0;
  int  failAt = -1;
  int  frLeft = 0;
  int  frBeat = 0;
  int  frAddr = 0;
  bit  frGap = 1'b0;
  int  runLen = 0;
  int  committed = 0;
  bit  prevOwn = 1'b0;
  bit  hostPhase = 1'b1;

  always @(negedge clk) begin
    if (rstN) begin
      // every-clock comparisons
      if (!busOwn)
        chk(!memOe && !memRdReq && !memWrEn && memAddr == '0 && memWrData == '0,
            "R2 released bus quiet", {memOe, memRdReq, memWrEn}, '0);
      if (memOe && !prevOwn)
        chk(1'b0, "R3 driver enable without prior ownership", memOe, 0);
      if (hostPhase)
        chk(!busOwn, "R2 host phase ownership", busOwn, 0);
      prevOwn = busOwn;

      // DRAM read returns
      memRdValid = 1'b0;
      if (rdDelay == 1) begin
        memRdValid = 1'b1;
        memRdData  = dram[rdAddrD];
      end
      if (rdDelay > 0) rdDelay--;
      if (memRdReq) begin
        chk(int'(memAddr) == expRdAddr, "R4 read address order", memAddr, expRdAddr);
        expRdAddr++;
        rdAddrD = int'(memAddr);
        rdDelay = 1 + int'(memAddr) % 3;
      end

      // flash write beats and commit
      flashAck  = 1'b0;
      flashFail = 1'b0;
      if (ackCnt == 1) begin
        flashAck  = 1'b1;
        flashFail = (ackAddr == failAt);
        if (ackAddr != failAt) committed++;
      end
      if (ackCnt > 0) ackCnt--;
      if (flashWrValid) begin
        chk(flashWrData == expBeat(dram[flashAddr], wBeat), "R5 flash beat content",
            flashWrData, expBeat(dram[flashAddr], wBeat));
        flashMem[flashAddr][wBeat] = flashWrData;
        wBeat++;
        if (wBeat == BEATS) begin
          wBeat   = 0;
          ackAddr = int'(flashAddr);
          ackCnt  = 1 + int'(flashAddr) % 2;
        end
      end

      // flash read beats, with one idle gap per word
      flashRdValid = 1'b0;
      if (frLeft > 0) begin
        if (frGap) begin
          frGap = 1'b0;
        end else begin
          flashRdValid = 1'b1;
          flashRdData  = flashMem[frAddr][frBeat];
          frBeat++;
          frLeft--;
          frGap = (frBeat == 2);
        end
      end
      if (flashRdReq) begin
        frLeft = BEATS;
        frBeat = 0;
        frAddr = int'(flashAddr);
        frGap  = 1'b0;
      end

      // stretched DRAM writes
      if (memWrEn) begin
        if (runLen == 0) begin
          chk(int'(memAddr) == expWrAddr, "R10 restore write address", memAddr, expWrAddr);
          chk(memWrData == saved[memAddr], "R10 restore write data", memWrData, saved[memAddr]);
          dram[memAddr] = memWrData;
        end
        runLen++;
      end else if (runLen > 0) begin
        chk(runLen == SLOW_DIV, "R13 write strobe length", runLen, SLOW_DIV);
        runLen = 0;
        expWrAddr++;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseRegRst();
    @(negedge clk);
    regRstN = 1'b0;
    @(negedge clk);
    regRstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      dram[i]  = {8'(i * 37 + 5), 64'hA5C3_0000_0000_1E2F ^ (64'(i + 1) * 64'h0123_4567_89AB_CDEF)};
      saved[i] = dram[i];
      for (int b = 0; b < BEATS; b++) flashMem[i][b] = '0;
    end

    tick(3);
    chk(!busOwn && !memOe && !done && !errSticky && statusCode == 3'd0, "R1 reset state",
        {busOwn, memOe, done, errSticky, statusCode}, 0);
    @(negedge clk);
    rstN = 1'b1;
    tick(4);
    chk(!busOwn && statusCode == 3'd0, "R1 idle after reset", busOwn, 0);

    // restore request with a clean cache is ignored
    restoreReq = 1'b1;
    @(negedge clk);
    restoreReq = 1'b0;
    tick(3);
    chk(!busOwn && statusCode == 3'd0 && !done, "R11 clean restore ignored", statusCode, 0);

    // power fail with a clean cache
    powerGood = 1'b0;
    @(negedge clk);
    chk(!busOwn && done && statusCode == 3'd2, "R6 clean skip", {done, statusCode}, {1'b1, 3'd2});
    tick(2);
    chk(!busOwn && done, "R6 skip holds", busOwn, 0);
    powerGood = 1'b1;
    @(negedge clk);
    regRstN = 1'b0;
    @(negedge clk);
    chk(!done && statusCode == 3'd0, "R12 status cleared", statusCode, 0);
    regRstN = 1'b1;
    tick(2);

    // backup of a dirty cache
    hostPhase   = 1'b0;
    expRdAddr   = 0;
    committed   = 0;
    cacheDirtyN = 1'b0;
    powerGood   = 1'b0;
    @(negedge clk);
    chk(busOwn && !memOe, "R3 takeover turnaround", {busOwn, memOe}, 2'b10);
    @(negedge clk);
    chk(busOwn && memOe, "R3 drivers enabled", {busOwn, memOe}, 2'b11);
    while (expRdAddr < 4) @(negedge clk);
    regRstN = 1'b0;
    tick(2);
    regRstN = 1'b1;
    chk(busOwn, "R9 backup continues under register reset", busOwn, 1);
    while (!done) @(negedge clk);
    chk(!busOwn && statusCode == 3'd1, "R7 backup complete", statusCode, 1);
    chk(expRdAddr == DEPTH, "R4 one read per word", expRdAddr, DEPTH);
    chk(committed == DEPTH, "R9 every word committed", committed, DEPTH);
    chk(flashMem[3][BEATS-1][FW-1:2*NIB_W] == '0, "R5 padding channels zero",
        flashMem[3][BEATS-1], 0);
    tick(3);
    chk(done && !busOwn && statusCode == 3'd1, "R7 done holds", statusCode, 1);

    // restore with power still bad is ignored
    restoreReq = 1'b1;
    @(negedge clk);
    restoreReq = 1'b0;
    tick(3);
    chk(!busOwn && statusCode == 3'd1, "R11 restore without power ignored", statusCode, 1);

    // full restore
    powerGood = 1'b1;
    for (int i = 0; i < DEPTH; i++) dram[i] = '0;
    expWrAddr  = 0;
    restoreReq = 1'b1;
    @(negedge clk);
    restoreReq = 1'b0;
    while (statusCode != 3'd3) @(negedge clk);
    chk(done && !busOwn, "R10 restore complete", {done, busOwn}, 2'b10);
    tick(1);
    chk(expWrAddr == DEPTH, "R10 one write per word", expWrAddr, DEPTH);
    for (int i = 0; i < DEPTH; i++)
      chk(dram[i] == saved[i], "R10 restored contents", dram[i], saved[i]);

    // restore aborted by register reset
    expWrAddr  = 0;
    restoreReq = 1'b1;
    @(negedge clk);
    restoreReq = 1'b0;
    while (!(expWrAddr == 2 && !memWrEn && runLen == 0)) @(negedge clk);
    regRstN = 1'b0;
    @(negedge clk);
    chk(!busOwn && !done && statusCode == 3'd0, "R12 restore aborted", {busOwn, statusCode}, 0);
    regRstN = 1'b1;
    tick(12);
    chk(!busOwn, "R12 stays idle after abort", busOwn, 0);

    // flash failure during backup
    expRdAddr = 0;
    failAt    = 5;
    powerGood = 1'b0;
    while (!errSticky) @(negedge clk);
    chk(!busOwn && statusCode == 3'd4, "R8 fault stop", statusCode, 4);
    chk(expRdAddr == 6, "R8 no read after failure", expRdAddr, 6);
    tick(10);
    chk(errSticky && statusCode == 3'd4 && !busOwn, "R8 fault sticky", errSticky, 1);
    powerGood = 1'b1;
    pulseRegRst();
    chk(!errSticky && statusCode == 3'd0 && !done, "R12 fault cleared", errSticky, 0);
    tick(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule